// File: doc/BRIEF.md
# Clock Output Enable Controller

This block decides, for each of eight clock pads, whether the pad carries its running clock or sits in a chosen idle state. The pads are grouped in four banks of two. Each bank receives one running source clock, and each pad may invert that clock on its own so that a bank can drive a complementary pair. Three controls can turn a bank off: an active-low enable pin that acts on every bank, a register bit that disables every bank, and a disable bit for each bank.

For each bank a 2-bit idle mode says what its pads do while disabled. They can float, hold low, hold high, or ignore all three controls and keep running. A pad switches between running and idle only at a sample where its own source clock (after inversion) is low. A change of control therefore never cuts a clock pulse short at the pad. A small register port with a synchronous write and a combinational read holds the disable bits, the idle modes and the inversion bits. The source clocks are slow compared with the control clock, and they arrive as levels that the control clock samples.

Top module: `clkout_enable_ctrl`

## Requirements
- R1: After reset every pad runs: pad_data follows its source clock, pad_oe is 1, and every register reads 0.
- R2: Register map. Address 0 holds the bank disable bits [3:0] (bit b = bank b, 1 = disabled) and the global disable bit [4]. Addresses 1 to 4 configure banks 0 to 3: bits [7:6] are the idle mode, bit 0 inverts the bank's first pad (pad 2b), and bit 1 inverts its second pad (pad 2b+1). Unused bits and addresses 5 to 7 read 0. rd_data is combinational from rd_addr.
- R3: While oe_pin_n is high, every bank whose mode is not 11 is disabled. The pin passes through a two-flop synchronizer, so with the source low a pin change reaches the pads at the third rising edge after it.
- R4: While the global disable bit is 1, every bank whose mode is not 11 is disabled, whatever the bank disable bits hold.
- R5: A bank disable bit set to 1 disables both pads of that bank and no others.
- R6: Idle modes: 00 gives pad_oe 0 and pad_data 0; 01 gives pad_oe 1 and pad_data 0; 10 gives pad_oe 1 and pad_data 1.
- R7: Mode 11 keeps a bank's pads running with pad_oe 1 regardless of the pin, the global bit and the bank bit.
- R8: A running pad drives its source clock, inverted when the pad's inversion bit is 1.
- R9: A pad changes between running and idle only at a rising edge where its inverted-as-configured source is low. While that source stays high, the pad keeps its previous state.
- R10: With the source low, a register write takes effect at the pads one rising edge after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_pin_n | input | 1 | Asynchronous enable pin; high disables |
| src_clk | input | 4 | Running source clock for each bank |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| pad_data | output | 8 | Data level for each pad |
| pad_oe | output | 8 | Output enable for each pad |

## Verification
The bench sweeps every combination of pin level, global bit and bank disable pattern against rotating idle modes and varied inversion patterns. It checks each pad at both levels of its source, which exposes a priority that is wrongly ordered, for example bank bits that still act while the global bit is set, or an always-on bank that stops. It holds the source high while the controls change, to catch a design that gates in mid-pulse. It counts edges from a pin change and from a register write, to catch a synchronizer of the wrong depth or an extra pipeline stage. The register readback checks catch field bits that land in the wrong place and unmapped addresses that alias onto real registers.

// File: rtl/clkout_en_pkg.sv
// Shared types for the clock output enable controller.
// Assumes nothing beyond a 2-bit idle mode per bank.
package clkout_en_pkg;
    typedef enum logic [1:0] {
        IDLE_FLOAT  = 2'b00,
        IDLE_LOW    = 2'b01,
        IDLE_HIGH   = 2'b10,
        IDLE_ALWAYS = 2'b11
    } idle_mode_e;
endpackage

// File: rtl/clkout_en_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level; the output is RST_VAL while in reset.
module clkout_en_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/clkout_en_regs.sv
// Register file: disable bits, per-bank idle mode and per-pad inversion.
// Assumes NUM_BANKS + 1 <= DATA_W and NUM_BANKS < 2**ADDR_W.
module clkout_en_regs
    import clkout_en_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int OUTS_PER_BANK = 2,
    parameter int ADDR_W        = 3,
    parameter int DATA_W        = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    output logic [NUM_BANKS-1:0]                bank_dis,
    output logic                                glob_dis,
    output idle_mode_e [NUM_BANKS-1:0]          mode,
    output logic [NUM_BANKS*OUTS_PER_BANK-1:0]  inv
);
    localparam int MODE_LSB = DATA_W - 2;
    localparam int NOUT     = NUM_BANKS * OUTS_PER_BANK;

    logic [NUM_BANKS:0]           ctl_q;
    idle_mode_e [NUM_BANKS-1:0]   mode_q;
    logic [NOUT-1:0]              inv_q;

    // Store writes to the control word and the bank configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            mode_q <= {NUM_BANKS{IDLE_FLOAT}};
            inv_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == '0) ctl_q <= wr_data[NUM_BANKS:0];
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (wr_addr == ADDR_W'(b + 1)) begin
                    mode_q[b] <= idle_mode_e'(wr_data[MODE_LSB +: 2]);
                    inv_q[b*OUTS_PER_BANK +: OUTS_PER_BANK] <= wr_data[OUTS_PER_BANK-1:0];
                end
            end
        end
    end

    // Return the addressed word; unmapped bits and addresses read zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data[NUM_BANKS:0] = ctl_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_addr == ADDR_W'(b + 1)) begin
                rd_data[MODE_LSB +: 2]       = mode_q[b];
                rd_data[OUTS_PER_BANK-1:0]   = inv_q[b*OUTS_PER_BANK +: OUTS_PER_BANK];
            end
        end
    end

    assign bank_dis = ctl_q[NUM_BANKS-1:0];
    assign glob_dis = ctl_q[NUM_BANKS];
    assign mode     = mode_q;
    assign inv      = inv_q;

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> (glob_dis == $past(wr_data[NUM_BANKS])));
endmodule

// File: rtl/clkout_en_lane.sv
// One pad: gates its source clock and drives the idle level.
// Assumes src is a level sampled by clk; the gate changes only while the
// inverted-as-configured source is low.
module clkout_en_lane
    import clkout_en_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src,
    input  logic       inv,
    input  logic       want_on,
    input  idle_mode_e mode,
    output logic       pad_data,
    output logic       pad_oe
);
    logic src_eff;
    logic gate_q;

    assign src_eff = src ^ inv;

    // Follow the requested state only while the pad's clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n)        gate_q <= 1'b1;
        else if (!src_eff) gate_q <= want_on;
    end

    // Pick the pad level: running clock or the idle level of the mode.
    always_comb begin
        if (gate_q) begin
            pad_data = src_eff;
            pad_oe   = 1'b1;
        end else begin
            unique case (mode)
                IDLE_FLOAT:  begin pad_data = 1'b0; pad_oe = 1'b0; end
                IDLE_LOW:    begin pad_data = 1'b0; pad_oe = 1'b1; end
                IDLE_HIGH:   begin pad_data = 1'b1; pad_oe = 1'b1; end
                default:     begin pad_data = 1'b0; pad_oe = 1'b1; end
            endcase
        end
    end

    // R9
    gate_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gate_q) |-> $past(!src_eff));

    // R6
    float_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_oe |-> (mode == IDLE_FLOAT && !pad_data));
endmodule

// File: rtl/clkout_enable_ctrl.sv
// Top: combines pin, global and bank disables with per-bank idle modes
// and drives eight pads in banks of two.
// Assumes source clocks are much slower than clk and arrive as levels.
module clkout_enable_ctrl
    import clkout_en_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int OUTS_PER_BANK = 2,
    parameter int ADDR_W        = 3,
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                oe_pin_n,
    input  logic [NUM_BANKS-1:0]                src_clk,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    output logic [NUM_BANKS*OUTS_PER_BANK-1:0]  pad_data,
    output logic [NUM_BANKS*OUTS_PER_BANK-1:0]  pad_oe
);
    localparam int NOUT = NUM_BANKS * OUTS_PER_BANK;

    logic                        pin_off;
    logic [NUM_BANKS-1:0]        bank_dis;
    logic                        glob_dis;
    idle_mode_e [NUM_BANKS-1:0]  mode;
    logic [NOUT-1:0]             inv;
    logic [NUM_BANKS-1:0]        want_on;

    clkout_en_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) pin_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (oe_pin_n),
        .q     (pin_off)
    );

    clkout_en_regs #(
        .NUM_BANKS     (NUM_BANKS),
        .OUTS_PER_BANK (OUTS_PER_BANK),
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .bank_dis (bank_dis),
        .glob_dis (glob_dis),
        .mode     (mode),
        .inv      (inv)
    );

    // Resolve enable priority per bank: always-on beats every disable.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            want_on[b] = (mode[b] == IDLE_ALWAYS) || !(pin_off || glob_dis || bank_dis[b]);
        end
    end

    for (genvar i = 0; i < NOUT; i++) begin : g_lane
        localparam int BANK = i / OUTS_PER_BANK;

        clkout_en_lane lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src_clk[BANK]),
            .inv      (inv[i]),
            .want_on  (want_on[BANK]),
            .mode     (mode[BANK]),
            .pad_data (pad_data[i]),
            .pad_oe   (pad_oe[i])
        );

        // R7
        always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[BANK] == IDLE_ALWAYS && $past(mode[BANK] == IDLE_ALWAYS)) |-> pad_oe[i]);
    end
endmodule

// File: tb/clkout_enable_ctrl_tb.sv
// Self-checking bench: register readback, full sweep of the enable
// controls, gating at the source's low phase and edge-count latency.
module clkout_enable_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe_pin_n = 1'b0;
    logic [3:0] src_clk = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] pad_data;
    logic [7:0] pad_oe;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    clkout_enable_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_pin_n (oe_pin_n),
        .src_clk  (src_clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pad_data (pad_data),
        .pad_oe   (pad_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, $sformatf("read addr %0d", a), rd_data, exp);
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, both source levels
        src_clk = 4'hF; #1;
        chk("R1", "pad_data src high", pad_data, 8'hFF);
        chk("R1", "pad_oe", pad_oe, 8'hFF);
        @(negedge clk); src_clk = 4'h0; #1;
        chk("R1", "pad_data src low", pad_data, 8'h00);
        for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1");

        // R2: field placement and unmapped addresses
        wr(3'd0, 8'hFF);
        rd(3'd0, 8'h1F, "R2");
        for (int b = 0; b < 4; b++) wr(3'(b + 1), 8'hFF ^ 8'(b << 6));
        for (int b = 0; b < 4; b++) rd(3'(b + 1), 8'hC3 ^ 8'(b << 6), "R2");
        for (int a = 5; a < 8; a++) rd(3'(a), 8'h00, "R2");

        // Sweep: mode rotation x bank bits x global bit x pin
        for (int m = 0; m < 4; m++) begin
            for (int ind = 0; ind < 16; ind++) begin
                for (int g = 0; g < 2; g++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [7:0] invp;
                        logic [1:0] md [4];
                        invp = 8'((ind * 37 + m * 11 + g * 5 + p * 3) & 255);
                        wr(3'd0, 8'((g << 4) | ind));
                        for (int b = 0; b < 4; b++) begin
                            md[b] = 2'((m + b) % 4);
                            wr(3'(b + 1), {md[b], 4'b0000, invp[2*b +: 2]});
                        end
                        @(negedge clk); oe_pin_n = p[0];
                        for (int t = 0; t < 8; t++) begin
                            @(negedge clk); src_clk = ~src_clk;
                        end
                        for (int s = 0; s < 2; s++) begin
                            @(negedge clk); src_clk = {4{s[0]}}; #1;
                            for (int i = 0; i < 8; i++) begin
                                int    b;
                                logic  on, ed, eo;
                                string req;
                                b  = i / 2;
                                on = (md[b] == 2'b11) || !(p[0] || g[0] || ind[b]);
                                if (on) begin
                                    ed = s[0] ^ invp[i]; eo = 1'b1;
                                    req = (md[b] == 2'b11) ? "R7" : "R8";
                                end else begin
                                    ed = (md[b] == 2'b10); eo = (md[b] != 2'b00);
                                    if (p[0])           req = "R3 R6";
                                    else if (g[0])      req = "R4 R6";
                                    else                req = "R5 R6";
                                end
                                chk(req, $sformatf("pad %0d data m%0d ind%0h g%0d p%0d", i, m, ind, g, p),
                                    pad_data[i], ed);
                                chk(req, $sformatf("pad %0d oe m%0d ind%0h g%0d p%0d", i, m, ind, g, p),
                                    pad_oe[i], eo);
                            end
                        end
                    end
                end
            end
        end

        // R9: no change while the source is held high
        oe_pin_n = 1'b0;
        wr(3'd0, 8'h00);
        for (int b = 0; b < 4; b++) wr(3'(b + 1), 8'h00);
        @(negedge clk); src_clk = 4'h0;
        repeat (2) @(negedge clk);
        src_clk = 4'hF;
        wr(3'd0, 8'h10);
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "oe held while source high", pad_oe, 8'hFF);
        chk("R9", "data held while source high", pad_data, 8'hFF);
        src_clk = 4'h0; #1;
        chk("R9", "oe before low-phase edge", pad_oe, 8'hFF);
        @(posedge clk); #1;
        chk("R9", "oe after low-phase edge", pad_oe, 8'h00);

        // R10: register write latency
        wr(3'd0, 8'h00);
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h02;
        @(posedge clk); #1;
        chk("R10", "oe one edge after write", pad_oe, 8'hFF);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        chk("R10", "oe two edges after write", pad_oe, 8'hF3);

        // R3: pin latency through the synchronizer
        wr(3'd0, 8'h00);
        repeat (2) @(negedge clk);
        oe_pin_n = 1'b1;
        @(posedge clk); #1;
        chk("R3", "pin edge 1", pad_oe, 8'hFF);
        @(posedge clk); #1;
        chk("R3", "pin edge 2", pad_oe, 8'hFF);
        @(posedge clk); #1;
        chk("R3", "pin edge 3", pad_oe, 8'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule